// File: doc/BRIEF.md
# Single-Wire Bus ROM Command Layer

This block sits between the bit-level engine of a single-wire slave link and the layer that runs device function commands. After each bus reset it collects a command byte from the bits the master writes. Depending on that byte it then sends the 64-bit device identity, compares the identity against bits the master writes, or takes part in the three-slot search arbitration. It also keeps two flags. The resume flag lets a device that was addressed earlier skip addressing. The overdrive flag tells the link to switch to fast timing.

When addressing succeeds, the block pulses a grant for one cycle to the function layer. From then until the next bus reset it leaves the bus alone. If addressing fails, or the command byte is unknown, the block goes quiet until the next reset.

The identity is built from a 56-bit input that carries the family code in the low byte and the serial number above it. An internal CRC-8 supplies the top byte. The link engine reports each master write slot as `wr_stb` with `wr_bit`, and each master read slot as `rd_stb`. During a read slot the engine drives the value on `tx_bit`, where 1 means the line is released.

Top module: `ow_rom_layer`

## Requirements
- R1: After power-on reset, `od_mode` and `resume_ok` are 0, `fn_grant` is 0 and `tx_bit` is 1. Until the first `link_reset`, all slots are ignored, so a skip byte gives no grant.
- R2: The identity is {crc, id_base}, sent LSB first, so bit 0 is `id_base[0]` (the family byte is `id_base[7:0]`). The crc is x^8+x^5+x^4+1, starts at zero and is shifted LSB first over the 56 base bits. Passing the full 64 bits through the same CRC gives zero.
- R3: Command 33h sends the 64 identity bits on the next 64 read slots, then grants. It clears the resume flag.
- R4: Command 55h clears the resume flag and compares the next 64 written bits with the identity. If all 64 match, the block grants and sets the resume flag. On the first mismatch there is no grant, and reads return 1 until the next reset.
- R5: Command F0h runs 64 triplets. In each, the block sends the identity bit, then its complement, then reads the master's bit. A differing bit drops the device: later reads return 1 and there is no grant. A full pass grants and sets the resume flag.
- R6: Command CCh grants at once and clears the resume flag.
- R7: Command A5h grants only if the resume flag is set; otherwise the device ignores the bus until reset. The resume flag is kept across bus resets.
- R8: Command 3Ch sets `od_mode`, grants and clears the resume flag.
- R9: Command 69h sets `od_mode` and clears the resume flag as soon as the command byte arrives. It then behaves like 55h for the 64 compare bits.
- R10: `od_mode` is cleared only by a `link_reset` with `link_reset_long` high. A short reset keeps it.
- R11: Any other command byte gives no grant, and the device ignores the bus until reset.
- R12: `fn_grant` is a single-cycle pulse, at most one per reset. After it, slots are not decoded and reads return 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_reset | input | 1 | One-cycle pulse: bus reset seen |
| link_reset_long | input | 1 | Qualifies `link_reset` as long enough to leave overdrive |
| wr_stb | input | 1 | One-cycle pulse: master write slot done |
| wr_bit | input | 1 | Bit written by the master |
| rd_stb | input | 1 | One-cycle pulse: master read slot done |
| id_base | input | 56 | Family code (bits 7:0) and serial number |
| tx_bit | output | 1 | Value to drive in the current read slot (1 = release) |
| fn_grant | output | 1 | One-cycle grant to the function layer |
| od_mode | output | 1 | Overdrive speed flag |
| resume_ok | output | 1 | Resume flag |

## Verification
Two identities are used. One is a known vector whose CRC byte is checked against a fixed value. The other is checked against a CRC the bench computes byte-wise, which separates a wrong polynomial or bit order from a correct one.

Compare runs use the exact identity, a copy with one bit flipped, and a search in which the master picks the wrong bit partway through. Together these show that a drop happens at the differing bit, and not only at the end.

Resume is tried with the flag set and with it cleared. Overdrive is tried across a short reset and a long reset. Bytes are also sent after a grant and after a drop, which shows that the block leaves the bus alone.

// File: rtl/ow_rom_pkg.sv
package ow_rom_pkg;

  typedef enum logic [2:0] {
    ST_DROP,    // ignoring the bus until reset
    ST_CMD,     // collecting the command byte
    ST_READ,    // sending the identity
    ST_MATCH,   // comparing written bits with the identity
    ST_SRCH_T,  // search: send true bit
    ST_SRCH_C,  // search: send complement
    ST_SRCH_S,  // search: read master selection
    ST_FUNC     // granted, function layer owns the bus
  } rom_state_e;

  localparam logic [7:0] CMD_READ     = 8'h33;
  localparam logic [7:0] CMD_MATCH    = 8'h55;
  localparam logic [7:0] CMD_SEARCH   = 8'hF0;
  localparam logic [7:0] CMD_SKIP     = 8'hCC;
  localparam logic [7:0] CMD_RESUME   = 8'hA5;
  localparam logic [7:0] CMD_OD_SKIP  = 8'h3C;
  localparam logic [7:0] CMD_OD_MATCH = 8'h69;

  // One serial step of the x^8+x^5+x^4+1 CRC, LSB-first form.
  function automatic logic [7:0] crc8_shift(input logic [7:0] crc, input logic b);
    logic fb;
    fb = crc[0] ^ b;
    crc8_shift = {1'b0, crc[7:1]} ^ (fb ? 8'h8C : 8'h00);
  endfunction

endpackage

// File: rtl/ow_rom_id.sv
module ow_rom_id
  import ow_rom_pkg::*;
#(
  parameter int BASE_W = 56,
  parameter int CRC_W  = 8
) (
  input  logic [BASE_W-1:0]       base,
  output logic [BASE_W+CRC_W-1:0] id
);
  localparam int ID_W = BASE_W + CRC_W;

  logic [CRC_W-1:0] crc_base;

  always_comb begin
    crc_base = '0;
    for (int i = 0; i < BASE_W; i++) crc_base = crc8_shift(crc_base, base[i]);
  end

  assign id = {crc_base, base};

  // Running the whole identity through the CRC must leave zero.
  always_comb begin
    logic [CRC_W-1:0] crc_all;
    crc_all = '0;
    for (int i = 0; i < ID_W; i++) crc_all = crc8_shift(crc_all, id[i]);
    if (!$isunknown(id))
      AST_CRC_RESIDUE_ZERO: assert (crc_all == '0); // R2
  end

endmodule

// File: rtl/ow_rom_byte_rx.sv
module ow_rom_byte_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] data,
  output logic         done
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      data <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clear) begin
        cnt <= '0;
      end else if (en) begin
        data <= {din, data[W-1:1]};
        if (cnt == LAST) begin
          cnt  <= '0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

endmodule

// File: rtl/ow_rom_layer.sv
module ow_rom_layer
  import ow_rom_pkg::*;
#(
  parameter int BASE_W = 56,
  parameter int CRC_W  = 8,
  parameter int CMD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_reset,
  input  logic              link_reset_long,
  input  logic              wr_stb,
  input  logic              wr_bit,
  input  logic              rd_stb,
  input  logic [BASE_W-1:0] id_base,
  output logic              tx_bit,
  output logic              fn_grant,
  output logic              od_mode,
  output logic              resume_ok
);
  localparam int ID_W  = BASE_W + CRC_W;
  localparam int IDX_W = $clog2(ID_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_W - 1);

  rom_state_e        st;
  logic [IDX_W-1:0]  idx;
  logic [ID_W-1:0]   id;
  logic [CMD_W-1:0]  cmd_byte;
  logic              cmd_valid;

  // Named events used by the FSM and the assertions.
  logic cur_bit, bit_ok, last_bit, cmd_en;
  assign cur_bit  = id[idx];
  assign bit_ok   = (wr_bit == cur_bit);
  assign last_bit = (idx == LAST_IDX);
  assign cmd_en   = wr_stb && (st == ST_CMD) && !link_reset;

  ow_rom_id #(.BASE_W(BASE_W), .CRC_W(CRC_W)) u_id (
    .base (id_base),
    .id   (id)
  );

  ow_rom_byte_rx #(.W(CMD_W)) u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (link_reset),
    .en    (cmd_en),
    .din   (wr_bit),
    .data  (cmd_byte),
    .done  (cmd_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_DROP;
      idx       <= '0;
      fn_grant  <= 1'b0;
      od_mode   <= 1'b0;
      resume_ok <= 1'b0;
    end else begin
      fn_grant <= 1'b0;
      if (link_reset) begin
        st  <= ST_CMD;
        idx <= '0;
        if (link_reset_long) od_mode <= 1'b0;
      end else begin
        unique case (st)
          ST_CMD: if (cmd_valid) begin
            idx <= '0;
            unique case (cmd_byte)
              CMD_READ:     begin resume_ok <= 1'b0; st <= ST_READ; end
              CMD_MATCH:    begin resume_ok <= 1'b0; st <= ST_MATCH; end
              CMD_OD_MATCH: begin resume_ok <= 1'b0; od_mode <= 1'b1; st <= ST_MATCH; end
              CMD_SEARCH:   begin resume_ok <= 1'b0; st <= ST_SRCH_T; end
              CMD_SKIP:     begin resume_ok <= 1'b0; st <= ST_FUNC; fn_grant <= 1'b1; end
              CMD_OD_SKIP:  begin
                resume_ok <= 1'b0; od_mode <= 1'b1; st <= ST_FUNC; fn_grant <= 1'b1;
              end
              CMD_RESUME:   begin
                if (resume_ok) begin st <= ST_FUNC; fn_grant <= 1'b1; end
                else st <= ST_DROP;
              end
              default:      st <= ST_DROP;
            endcase
          end
          ST_READ: if (rd_stb) begin
            if (last_bit) begin st <= ST_FUNC; fn_grant <= 1'b1; end
            else idx <= idx + 1'b1;
          end
          ST_MATCH: if (wr_stb) begin
            if (!bit_ok) st <= ST_DROP;
            else if (last_bit) begin
              st <= ST_FUNC; fn_grant <= 1'b1; resume_ok <= 1'b1;
            end else idx <= idx + 1'b1;
          end
          ST_SRCH_T: if (rd_stb) st <= ST_SRCH_C;
          ST_SRCH_C: if (rd_stb) st <= ST_SRCH_S;
          ST_SRCH_S: if (wr_stb) begin
            if (!bit_ok) st <= ST_DROP;
            else if (last_bit) begin
              st <= ST_FUNC; fn_grant <= 1'b1; resume_ok <= 1'b1;
            end else begin
              idx <= idx + 1'b1; st <= ST_SRCH_T;
            end
          end
          default: ; // ST_DROP, ST_FUNC hold until reset
        endcase
      end
    end
  end

  always_comb begin
    unique case (st)
      ST_READ, ST_SRCH_T: tx_bit = cur_bit;
      ST_SRCH_C:          tx_bit = ~cur_bit;
      default:            tx_bit = 1'b1;
    endcase
  end

  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fn_grant |=> !fn_grant); // R12
  AST_GRANT_IN_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
    fn_grant |-> (st == ST_FUNC)); // R12
  AST_FUNC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FUNC && !link_reset) |=> (st == ST_FUNC && !fn_grant)); // R12
  AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DROP && !link_reset) |=> (st == ST_DROP && !fn_grant)); // R11
  AST_OD_SET_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(od_mode) |-> $past(st == ST_CMD && cmd_valid &&
                             (cmd_byte == CMD_OD_SKIP || cmd_byte == CMD_OD_MATCH))); // R8
  AST_OD_CLEAR_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(od_mode) |-> $past(link_reset && link_reset_long)); // R10
  AST_RESUME_SET_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_ok) |-> fn_grant); // R4
  AST_RESUME_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CMD && cmd_valid && cmd_byte == CMD_RESUME && !resume_ok) |=> !fn_grant); // R7

endmodule

// File: tb/ow_rom_layer_test.sv
module ow_rom_layer_test;
  logic clk = 1'b0;
  logic rst_n, link_reset, link_reset_long, wr_stb, wr_bit, rd_stb;
  logic [55:0] id_base;
  logic tx_bit, fn_grant, od_mode, resume_ok;

  int checks = 0, fails = 0, grant_cnt = 0, grant_wide = 0;
  logic grant_q = 1'b0;

  always #5 clk = ~clk;

  ow_rom_layer uut (
    .clk(clk), .rst_n(rst_n), .link_reset(link_reset), .link_reset_long(link_reset_long),
    .wr_stb(wr_stb), .wr_bit(wr_bit), .rd_stb(rd_stb), .id_base(id_base),
    .tx_bit(tx_bit), .fn_grant(fn_grant), .od_mode(od_mode), .resume_ok(resume_ok)
  );

  always @(posedge clk) begin
    if (fn_grant) grant_cnt++;
    if (fn_grant && grant_q) grant_wide++;
    grant_q = fn_grant;
  end

  // Byte-wise CRC, independent of the serial form in the design.
  function automatic logic [63:0] exp_id(input logic [55:0] b);
    logic [7:0] c;
    c = 8'h00;
    for (int k = 0; k < 7; k++) begin
      c = c ^ b[k*8 +: 8];
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 8'h8C) : (c >> 1);
    end
    return {c, b};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_reset(input bit lng);
    @(negedge clk); link_reset = 1'b1; link_reset_long = lng;
    @(negedge clk); link_reset = 1'b0; link_reset_long = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic write_bit(input logic b);
    @(negedge clk); wr_bit = b; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) write_bit(v[i]);
    repeat (2) @(negedge clk);
  endtask

  task automatic read_bit(output logic b);
    @(negedge clk); b = tx_bit; rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic match_id(input logic [63:0] v);
    for (int i = 0; i < 64; i++) write_bit(v[i]);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_power_on();
    logic b;
    check(od_mode == 0 && resume_ok == 0 && fn_grant == 0 && tx_bit == 1, "R1 reset state",
          {od_mode, resume_ok, fn_grant, tx_bit}, 64'h1);
    grant_cnt = 0;
    write_byte(8'hCC);
    read_bit(b);
    check(grant_cnt == 0 && b == 1, "R1 ignored before first bus reset", grant_cnt, 0);
  endtask

  task automatic t_crc_known();
    logic [63:0] got;
    id_base = 56'h00000001B81C02;
    bus_reset(1);
    write_byte(8'h33);
    for (int i = 0; i < 64; i++) begin
      logic b;
      read_bit(b);
      got[i] = b;
    end
    check(got[63:56] == 8'hA2, "R2 known CRC byte", got[63:56], 8'hA2);
    check(got == exp_id(id_base), "R3 read identity LSB first", got, exp_id(id_base));
  endtask

  task automatic t_read(input logic [55:0] base);
    logic [63:0] got;
    id_base = base;
    bus_reset(1);
    grant_cnt = 0;
    write_byte(8'h55);
    match_id(exp_id(base));          // sets the resume flag
    bus_reset(0);
    grant_cnt = 0;
    write_byte(8'h33);
    check(resume_ok == 0, "R3 read clears resume flag", resume_ok, 0);
    for (int i = 0; i < 64; i++) begin
      logic b;
      read_bit(b);
      got[i] = b;
    end
    repeat (2) @(negedge clk);
    check(got == exp_id(base), "R2 identity with computed CRC", got, exp_id(base));
    check(grant_cnt == 1, "R3 grant after 64 bits", grant_cnt, 1);
  endtask

  task automatic t_match();
    logic [63:0] v;
    logic b;
    v = exp_id(id_base);
    bus_reset(0);
    grant_cnt = 0;
    write_byte(8'h55);
    match_id(v);
    check(grant_cnt == 1 && resume_ok == 1, "R4 exact match grants, sets flag",
          {grant_cnt, resume_ok}, {32'd1, 1'b1});
    // After grant: further slots not decoded
    write_byte(8'hCC);
    read_bit(b);
    check(grant_cnt == 1 && b == 1, "R12 slots ignored after grant", grant_cnt, 1);
    check(grant_wide == 0, "R12 grant is a single cycle", grant_wide, 0);
    // Mismatch at bit 40
    bus_reset(0);
    grant_cnt = 0;
    v[40] = ~v[40];
    write_byte(8'h55);
    for (int i = 0; i <= 40; i++) write_bit(v[i]);
    read_bit(b);
    check(b == 1, "R4 drop releases read slots", b, 1);
    for (int i = 41; i < 64; i++) write_bit(v[i]);
    write_byte(8'hCC);
    repeat (2) @(negedge clk);
    check(grant_cnt == 0 && resume_ok == 0, "R4 mismatch gives no grant",
          {grant_cnt, resume_ok}, 0);
  endtask

  task automatic t_search(input int wrong_at);
    logic [63:0] v;
    int errs;
    logic bt, bc;
    v = exp_id(id_base);
    errs = 0;
    bus_reset(0);
    grant_cnt = 0;
    write_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      read_bit(bt);
      read_bit(bc);
      if (wrong_at >= 0 && i > wrong_at) begin
        if (bt != 1 || bc != 1) errs++;
      end else if (bt != v[i] || bc != ~v[i]) errs++;
      write_bit(i == wrong_at ? ~v[i] : v[i]);
    end
    repeat (2) @(negedge clk);
    if (wrong_at < 0) begin
      check(errs == 0, "R5 triplet true/complement bits", errs, 0);
      check(grant_cnt == 1 && resume_ok == 1, "R5 full pass grants, sets flag",
            {grant_cnt, resume_ok}, {32'd1, 1'b1});
    end else begin
      check(errs == 0, "R5 dropped device releases slots", errs, 0);
      check(grant_cnt == 0 && resume_ok == 0, "R5 wrong select gives no grant",
            {grant_cnt, resume_ok}, 0);
    end
  endtask

  task automatic t_resume_skip();
    logic b;
    bus_reset(0);
    grant_cnt = 0;
    write_byte(8'hA5);
    check(grant_cnt == 1, "R7 resume grants with flag set", grant_cnt, 1);
    bus_reset(0);
    grant_cnt = 0;
    write_byte(8'hCC);
    check(grant_cnt == 1 && resume_ok == 0, "R6 skip grants, clears flag",
          {grant_cnt, resume_ok}, {32'd1, 1'b0});
    bus_reset(0);
    grant_cnt = 0;
    write_byte(8'hA5);
    read_bit(b);
    write_byte(8'hCC);
    check(grant_cnt == 0 && b == 1, "R7 resume without flag ignored until reset", grant_cnt, 0);
  endtask

  task automatic t_overdrive();
    logic [63:0] v;
    v = exp_id(id_base);
    bus_reset(1);
    write_byte(8'h55);
    match_id(v);
    bus_reset(0);
    grant_cnt = 0;
    write_byte(8'h69);
    check(od_mode == 1 && resume_ok == 0, "R9 overdrive match: flag set, resume cleared at command",
          {od_mode, resume_ok}, 64'h2);
    match_id(v);
    check(grant_cnt == 1 && resume_ok == 1, "R9 overdrive match grants",
          {grant_cnt, resume_ok}, {32'd1, 1'b1});
    bus_reset(0);
    check(od_mode == 1, "R10 short reset keeps overdrive", od_mode, 1);
    bus_reset(1);
    check(od_mode == 0, "R10 long reset clears overdrive", od_mode, 0);
    grant_cnt = 0;
    write_byte(8'h3C);
    check(od_mode == 1 && grant_cnt == 1 && resume_ok == 0, "R8 overdrive skip",
          {od_mode, grant_cnt, resume_ok}, {1'b1, 32'd1, 1'b0});
    bus_reset(1);
  endtask

  task automatic t_unknown();
    logic b;
    bus_reset(0);
    grant_cnt = 0;
    write_byte(8'h0F);
    read_bit(b);
    write_byte(8'hCC);
    check(grant_cnt == 0 && b == 1 && od_mode == 0, "R11 unknown command ignored", grant_cnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; link_reset = 1'b0; link_reset_long = 1'b0;
    wr_stb = 1'b0; wr_bit = 1'b0; rd_stb = 1'b0;
    id_base = 56'h5A6B7C8D9E0F3A;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_power_on();
    t_crc_known();
    t_read(56'h5A6B7C8D9E0F3A);
    t_match();
    t_search(-1);
    t_resume_skip();
    t_search(5);
    t_overdrive();
    t_unknown();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule